// File: doc/BRIEF.md
# One-Hot Sequenced Shift-Add Multiplier

This block multiplies two unsigned N-bit operands by repeated conditional addition and right shifting. A small control unit keeps one flip-flop for each of its three phases: idle, accumulate and shift. A separate decoder turns the phase lines, the start request and the low multiplier bit into the micro-operation strobes that drive an N-bit datapath.

The datapath holds the multiplicand register B, the accumulator A with its carry bit C, the multiplier/low-product register Q, and a down-counter P. Only one N-bit adder is used. The 2N-bit product builds up in {A,Q}, which is in place when the block returns to idle.

The operands are loaded into B and Q through a shared data bus with two load strobes. The user then raises the start input for one cycle and waits for the ready flag. The result is read from the product port.

Top module: `sam_mult_top`

## Requirements
- R1: `phase_o` has exactly one bit set in every cycle. Bit 0 is idle, bit 1 is accumulate and bit 2 is shift.
- R2: In idle, `go_i` high moves the block to accumulate at the next rising edge, and `go_i` low keeps it in idle. `done_o` is high exactly while in idle.
- R3: Accumulate always moves to shift. Shift moves to idle when the counter is zero and back to accumulate otherwise. So a run lasts exactly 2N busy cycles after the start edge, whatever the operand values.
- R4: `ctl_add_o` is high only in accumulate, and only when bit 0 of Q is 1. It loads A+B into {C,A}. Over one run it pulses once for each 1 bit of the multiplier.
- R5: `ctl_init_o` and `ctl_clrc_o` are high in the cycle that idle sees `go_i`. At that edge A and C are cleared and P is preset to N-1.
- R6: `ctl_shift_o` is high exactly in the shift phase. At that edge {C,A,Q} moves right by one bit and P decreases by one.
- R7: After a run, `product_o` = {A,Q} equals B times the multiplier as an unsigned 2N-bit value. This holds for every operand pair when N=4.
- R8: `load_b_i` and `load_q_i` copy `din_i` into B and Q on the rising edge where they are high. The shift micro-operation takes priority over a Q load in the same cycle.
- R9: The asynchronous reset `rst_i` forces idle at once, even in the middle of a run, and clears every datapath register.
- R10: `go_i` raised while a run is in progress has no effect. The run length and the product stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| go_i | input | 1 | Start request, sampled in idle only |
| load_b_i | input | 1 | Load multiplicand register from bus |
| load_q_i | input | 1 | Load multiplier register from bus |
| din_i | input | N | Operand bus |
| product_o | output | 2N | Product {A,Q} |
| done_o | output | 1 | Ready, high while idle |
| phase_o | output | 3 | One-hot phase lines |
| ctl_init_o | output | 1 | Initialise strobe (clear A, preset P) |
| ctl_clrc_o | output | 1 | Clear-carry strobe |
| ctl_add_o | output | 1 | Conditional add strobe |
| ctl_shift_o | output | 1 | Shift-and-decrement strobe |

## Verification
The hardest situation to reach is a start request or a reset that arrives while the sequencer is part way through its add/shift loop. Normal use only raises start in idle and only resets at power-up. The stimulus handles this in three ways. It injects an extra start pulse a few cycles into a run and checks that the run length and the product are unchanged. It also asserts reset in the middle of a run and checks that the phase lines return to idle at once. Finally, it sweeps all 256 operand pairs at N=4, so that every mix of add and no-add steps goes through the loop.

// File: rtl/sam_pkg.sv
package sam_pkg;
   // phase line positions of the one-hot state vector
   localparam int PH_IDLE = 0;
   localparam int PH_ACC  = 1;
   localparam int PH_SHR  = 2;
   localparam int NPH     = 3;

   typedef struct packed {
      logic init;
      logic clrc;
      logic add;
      logic shift;
   } sam_ctl_t;
endpackage

// File: rtl/sam_onehot_seq.sv
module sam_onehot_seq
   import sam_pkg::*;
(
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           go_i,
   input  logic           zero_i,
   output logic [NPH-1:0] ph_o
);
   logic [NPH-1:0] ph_q;
   logic [NPH-1:0] ph_d;

   // next-state terms taken straight from the chart junctions
   always_comb begin
      ph_d[PH_IDLE] = (ph_q[PH_IDLE] & ~go_i) | (ph_q[PH_SHR] & zero_i);
      ph_d[PH_ACC]  = (ph_q[PH_IDLE] &  go_i) | (ph_q[PH_SHR] & ~zero_i);
      ph_d[PH_SHR]  =  ph_q[PH_ACC];
   end

   // one flip-flop per phase; reset seeds the idle token
   for (genvar g = 0; g < NPH; g++) begin : g_ff
      localparam logic RST_VAL = (g == PH_IDLE);
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) ph_q[g] <= RST_VAL;
         else       ph_q[g] <= ph_d[g];
      end
   end

   assign ph_o = ph_q;

   AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(ph_q) == 1); // R1
   AST_IDLE_START: assert property (@(posedge clk_i) disable iff (rst_i)
      ph_q[PH_IDLE] && go_i |=> ph_q[PH_ACC]); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      ph_q[PH_IDLE] && !go_i |=> ph_q[PH_IDLE]); // R2
   AST_ACC_TO_SHR: assert property (@(posedge clk_i) disable iff (rst_i)
      ph_q[PH_ACC] |=> ph_q[PH_SHR]); // R3
   AST_SHR_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
      ph_q[PH_SHR] && zero_i |=> ph_q[PH_IDLE]); // R3
   AST_SHR_LOOP: assert property (@(posedge clk_i) disable iff (rst_i)
      ph_q[PH_SHR] && !zero_i |=> ph_q[PH_ACC]); // R3
endmodule

// File: rtl/sam_ctl_gen.sv
module sam_ctl_gen
   import sam_pkg::*;
(
   input  logic [NPH-1:0] ph_i,
   input  logic           go_i,
   input  logic           q0_i,
   output sam_ctl_t       ctl_o
);
   // micro-operation strobes; the multiplier bit gates the add only
   always_comb begin
      ctl_o.init  = ph_i[PH_IDLE] & go_i;
      ctl_o.clrc  = ph_i[PH_IDLE] & go_i;
      ctl_o.add   = ph_i[PH_ACC]  & q0_i;
      ctl_o.shift = ph_i[PH_SHR];
   end
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
   import sam_pkg::*;
#(
   parameter int N = 8
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  sam_ctl_t       ctl_i,
   input  logic           load_b_i,
   input  logic           load_q_i,
   input  logic [N-1:0]   din_i,
   output logic           q0_o,
   output logic           zero_o,
   output logic [2*N-1:0] prod_o
);
   localparam int          CW     = $clog2(N);
   localparam logic [CW-1:0] P_TOP = CW'(N - 1);

   logic [N-1:0]  a_q, b_q, q_q;
   logic          c_q;
   logic [CW-1:0] p_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         a_q <= '0;
         b_q <= '0;
         q_q <= '0;
         c_q <= 1'b0;
         p_q <= '0;
      end else begin
         if (load_b_i) b_q <= din_i;
         if (ctl_i.init) begin
            a_q <= '0;
            p_q <= P_TOP;
         end
         if (ctl_i.clrc) c_q <= 1'b0;
         if (ctl_i.add) {c_q, a_q} <= {1'b0, a_q} + {1'b0, b_q};
         if (ctl_i.shift) begin
            {c_q, a_q, q_q} <= {1'b0, c_q, a_q, q_q[N-1:1]};
            p_q <= p_q - CW'(1);
         end else if (load_q_i) begin
            q_q <= din_i;
         end
      end
   end

   assign q0_o   = q_q[0];
   assign zero_o = (p_q == '0);
   assign prod_o = {a_q, q_q};

   AST_INIT_PRESET: assert property (@(posedge clk_i) disable iff (rst_i)
      ctl_i.init |=> (p_q == P_TOP) && (a_q == '0) && !c_q); // R5
   AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (rst_i)
      ctl_i.add |=> {c_q, a_q} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)})); // R4
   AST_SHIFT_DEC: assert property (@(posedge clk_i) disable iff (rst_i)
      ctl_i.shift |=> p_q == $past(p_q) - CW'(1)); // R6
   AST_SHIFT_LINK: assert property (@(posedge clk_i) disable iff (rst_i)
      ctl_i.shift |=> (q_q[N-1] == $past(a_q[0])) && !c_q); // R6
endmodule

// File: rtl/sam_mult_top.sv
module sam_mult_top
   import sam_pkg::*;
#(
   parameter int N = 8
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           go_i,
   input  logic           load_b_i,
   input  logic           load_q_i,
   input  logic [N-1:0]   din_i,
   output logic [2*N-1:0] product_o,
   output logic           done_o,
   output logic [2:0]     phase_o,
   output logic           ctl_init_o,
   output logic           ctl_clrc_o,
   output logic           ctl_add_o,
   output logic           ctl_shift_o
);
   if (N < 2) begin : g_bad_width
      $error("sam_mult_top: N must be at least 2");
   end
   if (NPH != 3) begin : g_bad_phases
      $error("sam_mult_top: phase vector must have three lines");
   end

   logic [NPH-1:0] ph;
   logic           q0;
   logic           zero;
   sam_ctl_t       ctl;

   sam_onehot_seq u_seq (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .go_i   (go_i),
      .zero_i (zero),
      .ph_o   (ph)
   );

   sam_ctl_gen u_ctl (
      .ph_i  (ph),
      .go_i  (go_i),
      .q0_i  (q0),
      .ctl_o (ctl)
   );

   sam_datapath #(.N(N)) u_dp (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ctl_i    (ctl),
      .load_b_i (load_b_i),
      .load_q_i (load_q_i),
      .din_i    (din_i),
      .q0_o     (q0),
      .zero_o   (zero),
      .prod_o   (product_o)
   );

   assign phase_o     = ph;
   assign done_o      = ph[PH_IDLE];
   assign ctl_init_o  = ctl.init;
   assign ctl_clrc_o  = ctl.clrc;
   assign ctl_add_o   = ctl.add;
   assign ctl_shift_o = ctl.shift;
endmodule

// File: tb/sim_sam_mult_top.sv
`timescale 1ns/1ps
module sim_sam_mult_top;
   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           go = 1'b0;
   logic           ld_b = 1'b0;
   logic           ld_q = 1'b0;
   logic [N-1:0]   din = '0;
   logic [2*N-1:0] product;
   logic           done;
   logic [2:0]     phase;
   logic           c_init, c_clrc, c_add, c_shift;

   int n_chk = 0;
   int n_bad = 0;
   int ticks = 0;

   always #5 clk = ~clk;

   sam_mult_top #(.N(N)) u0 (
      .clk_i(clk), .rst_i(rst), .go_i(go), .load_b_i(ld_b), .load_q_i(ld_q),
      .din_i(din), .product_o(product), .done_o(done), .phase_o(phase),
      .ctl_init_o(c_init), .ctl_clrc_o(c_clrc), .ctl_add_o(c_add),
      .ctl_shift_o(c_shift)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      ticks++;
      if (ticks > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", ticks, 150000);
         summary();
      end
   end

   // loads operands, starts, and follows one run to completion
   task automatic run_mul(input int bv, input int qv, input bit poke_go);
      int cyc;
      int adds;
      longint expv;
      @(negedge clk); din = N'(bv); ld_b = 1'b1;
      @(negedge clk); ld_b = 1'b0; din = N'(qv); ld_q = 1'b1;
      @(negedge clk); ld_q = 1'b0; go = 1'b1;
      #1;
      chk(c_init && c_clrc, "R5 init/clear strobes on start", {c_init, c_clrc}, 3);
      @(negedge clk); go = 1'b0;
      cyc = 0;
      adds = 0;
      while (!done && cyc < 64) begin
         chk($countones(phase) == 1, "R1 one-hot phase", phase, 0);
         chk(c_shift == phase[2], "R6 shift strobe in shift phase", c_shift, phase[2]);
         if (c_add) adds++;
         go = (poke_go && cyc == 3);
         @(negedge clk);
         cyc++;
      end
      go = 1'b0;
      chk(cyc == 2 * N, "R3 run length", cyc, 2 * N);
      chk(adds == $countones(N'(qv)), "R4 add pulses", adds, $countones(N'(qv)));
      expv = longint'(bv) * longint'(qv);
      chk(longint'(product) == expv, poke_go ? "R10 product with stray start" : "R7 product",
          product, expv);
      chk(phase == 3'b001 && done, "R2 back in idle", phase, 1);
   endtask

   initial begin
      #12;
      chk(phase == 3'b001 && done, "R9 idle during reset", phase, 1);
      chk(product == '0, "R9 datapath cleared", product, 0);
      @(negedge clk); rst = 1'b0;
      // idle holds without start
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(phase == 3'b001 && !c_init, "R2 idle hold", phase, 1);
      end
      // loads alone do not start a run and are reflected in the product (R8)
      @(negedge clk); din = 4'hA; ld_q = 1'b1;
      @(negedge clk); ld_q = 1'b0;
      chk(product == 8'h0A, "R8 Q load visible in low product", product, 8'h0A);
      chk(phase == 3'b001, "R8 load leaves phase", phase, 1);

      // exhaustive sweep of operand pairs
      for (int ib = 0; ib < (1 << N); ib++) begin
         for (int iq = 0; iq < (1 << N); iq++) begin
            run_mul(ib, iq, 1'b0);
         end
      end
      // stray start while busy
      run_mul(15, 15, 1'b1);
      run_mul(9, 6, 1'b1);

      // Q load during shift phase loses to the shift (R8)
      @(negedge clk); din = 4'h3; ld_b = 1'b1;
      @(negedge clk); ld_b = 1'b0; din = 4'h5; ld_q = 1'b1;
      @(negedge clk); ld_q = 1'b0; go = 1'b1;
      @(negedge clk); go = 1'b0;
      @(negedge clk);
      chk(phase == 3'b100, "R8 in shift phase", phase, 4);
      din = 4'hF; ld_q = 1'b1;
      @(negedge clk); ld_q = 1'b0;
      while (!done) @(negedge clk);
      chk(product == 8'd15, "R8 shift wins over Q load", product, 15);

      // reset in the middle of a run
      @(negedge clk); din = 4'h7; ld_b = 1'b1;
      @(negedge clk); ld_b = 1'b0; ld_q = 1'b1;
      @(negedge clk); ld_q = 1'b0; go = 1'b1;
      @(negedge clk); go = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(!done, "R9 busy before reset", done, 0);
      rst = 1'b1;
      #1;
      chk(phase == 3'b001 && done, "R9 async reset to idle", phase, 1);
      chk(product == '0, "R9 reset clears product", product, 0);
      @(negedge clk); rst = 1'b0;
      run_mul(13, 11, 1'b0);
      summary();
   end
endmodule